// File: doc/BRIEF.md
# Multiplexed GPIO Port

This block owns a bank of general-purpose pins. Each pin is either driven by software through an output latch and a direction bit, or handed to one of several peripheral channels. A per-pin function-enable bit picks between the two, and a 2-bit field per pin picks which peripheral channel drives the pin when it is enabled.

Software reaches the block through a simple word-addressed register port. Writes take effect on the next clock edge and reads are combinational. The data and direction state can be changed either by writing a whole word or through write-one aliases that set or clear only the selected bits. Raw pad inputs pass through a two-flop synchronizer. The synchronized value is offered to software and, gated by the per-pin input enable, to a downstream pin-interrupt block.

Top module: `gpio_mux_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the function enable, the function select, the output latch, the direction and the input enable are all cleared. After reset every pin is a GPIO input with its output enable low, and every register reads zero.
- R2: When function-enable bit p is 1, `pad_out[p]` equals `per_out[s*NUM_PINS+p]` and `pad_oe[p]` equals `per_oe[s*NUM_PINS+p]`, where s is the pin's 2-bit select field.
- R3: When function-enable bit p is 0, `pad_out[p]` equals the output latch bit and `pad_oe[p]` equals the direction bit.
- R4: A write to address 3 (data set) sets each latch bit whose write bit is 1 and leaves the other bits unchanged. Reading address 3 returns the output latch.
- R5: A write to address 4 (data clear) clears each latch bit whose write bit is 1 and leaves the other bits unchanged. Reading address 4 returns the output latch.
- R6: A write to address 5 sets the direction bits that are 1 (1 means output), and a write to address 6 clears them. Bits written as 0 are unchanged. Reading address 5 or address 6 returns the current direction.
- R7: Reading address 2 returns, for each pin, the synchronized pad value when its input-enable bit is 1, or the output latch bit when it is 0. A pad change becomes visible after two clock edges.
- R8: `pad_irq_src` equals the synchronized pad value ANDed with the input enable.
- R9: A write to address 2 loads the whole output latch. Writes to address 0 (function enable) and address 7 (input enable) load those registers, and both addresses read them back. Without a write, no register changes.
- R10: Address 1 holds the function select, with pin p's field at bits 2p+1:2p. It reads back as written.
- R11: `pad_fsel` carries each pin's select field at bits 2p+1:2p when that pin's function enable is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register word address (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pad_in | input | 16 | Raw pad input values |
| per_out | input | 64 | Peripheral output values, channel f at bits f*16+p |
| per_oe | input | 64 | Peripheral output enables, same layout |
| pad_out | output | 16 | Value driven to each pad |
| pad_oe | output | 16 | Output enable for each pad |
| pad_fsel | output | 32 | Active peripheral select per pin |
| pad_irq_src | output | 16 | Gated synchronized inputs for the interrupt block |

## Verification
The assertions check on every cycle that reset clears the state and that set aliases never lower bits and clear aliases never raise them. They also check that the direction set alias only raises bits, that idle cycles leave the latches alone, that the synchronizer delivers the pad value two edges later, and that GPIO-owned pins drive the direction register onto the output enable. Only the bench's scenarios show the peripheral channel routing for each select code, and the readback selection between pad and latch under different input-enable patterns. The same holds for the interaction of random register traffic with intermittent resets, which the behavioural model follows cycle by cycle.

// File: rtl/gpio_mux_pkg.sv
// Shared register addresses for the multiplexed GPIO port.
// Assumes a 3-bit word address on the register port.
package gpio_mux_pkg;
    typedef enum logic [2:0] {
        RA_FUNC_EN  = 3'd0,
        RA_FSEL     = 3'd1,
        RA_DATA     = 3'd2,
        RA_DATA_SET = 3'd3,
        RA_DATA_CLR = 3'd4,
        RA_DIR_SET  = 3'd5,
        RA_DIR_CLR  = 3'd6,
        RA_IN_EN    = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/gpio_mux_sync.sv
// Two-flop synchronizer for the raw pad inputs.
// Assumes pads are asynchronous to clk; the output lags by two edges.
module gpio_mux_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the pad sample through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (d_sync == $past(d_in, 2))); // R7
endmodule

// File: rtl/gpio_mux_regs.sv
// Register file of the GPIO port: function enable, function select,
// output latch with set/clear aliases, direction with set/clear aliases,
// input enable, and the combinational read mux.
// Assumes NUM_PINS*SEL_W and NUM_PINS both fit in DATA_W.
module gpio_mux_regs
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int SEL_W    = 2,
    parameter int DATA_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [NUM_PINS-1:0]       pin_sync,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_PINS-1:0]       func_en_q,
    output logic [NUM_PINS*SEL_W-1:0] fsel_q,
    output logic [NUM_PINS-1:0]       data_q,
    output logic [NUM_PINS-1:0]       dir_q,
    output logic [NUM_PINS-1:0]       in_en_q
);
    localparam int FS_W = NUM_PINS * SEL_W;

    logic [NUM_PINS-1:0] wbits;
    assign wbits = wdata[NUM_PINS-1:0];

    // Apply register writes, including the write-one set/clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_en_q <= '0;
            fsel_q    <= '0;
            data_q    <= '0;
            dir_q     <= '0;
            in_en_q   <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_FUNC_EN:  func_en_q <= wbits;
                RA_FSEL:     fsel_q    <= wdata[FS_W-1:0];
                RA_DATA:     data_q    <= wbits;
                RA_DATA_SET: data_q    <= data_q | wbits;
                RA_DATA_CLR: data_q    <= data_q & ~wbits;
                RA_DIR_SET:  dir_q     <= dir_q | wbits;
                RA_DIR_CLR:  dir_q     <= dir_q & ~wbits;
                RA_IN_EN:    in_en_q   <= wbits;
                default:     ;
            endcase
        end
    end

    // Select the read word for the current address.
    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_FUNC_EN:              rdata[NUM_PINS-1:0] = func_en_q;
            RA_FSEL:                 rdata[FS_W-1:0]     = fsel_q;
            RA_DATA:                 rdata[NUM_PINS-1:0] = (in_en_q & pin_sync) | (~in_en_q & data_q);
            RA_DATA_SET, RA_DATA_CLR: rdata[NUM_PINS-1:0] = data_q;
            RA_DIR_SET, RA_DIR_CLR:  rdata[NUM_PINS-1:0] = dir_q;
            RA_IN_EN:                rdata[NUM_PINS-1:0] = in_en_q;
            default:                 rdata = '0;
        endcase
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (func_en_q == '0 && fsel_q == '0 && data_q == '0 && dir_q == '0 && in_en_q == '0)); // R1
    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_DATA_SET) |=> ((data_q & $past(data_q)) == $past(data_q))); // R4
    AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_DATA_CLR) |=> ((data_q | $past(data_q)) == $past(data_q))); // R5
    AST_DIR_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_DIR_SET) |=> ((dir_q & $past(dir_q)) == $past(dir_q))); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(data_q) && $stable(dir_q) && $stable(func_en_q) && $stable(in_en_q))); // R9
endmodule

// File: rtl/gpio_mux_pinsel.sv
// Per-pin output steering: GPIO latches or the selected peripheral channel.
// Assumes NUM_FUNC is a power of two so every select code names a channel.
module gpio_mux_pinsel #(
    parameter int NUM_PINS = 16,
    parameter int NUM_FUNC = 4,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_PINS-1:0]          func_en,
    input  logic [NUM_PINS*SEL_W-1:0]    fsel,
    input  logic [NUM_PINS-1:0]          data,
    input  logic [NUM_PINS-1:0]          dir,
    input  logic [NUM_FUNC*NUM_PINS-1:0] per_out,
    input  logic [NUM_FUNC*NUM_PINS-1:0] per_oe,
    output logic [NUM_PINS-1:0]          pin_out,
    output logic [NUM_PINS-1:0]          pin_oe,
    output logic [NUM_PINS*SEL_W-1:0]    pin_fsel
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [SEL_W-1:0] sel;
        logic             ch_out;
        logic             ch_oe;
        assign sel = fsel[p*SEL_W +: SEL_W];

        // Pick this pin's bit from the selected peripheral channel.
        always_comb begin
            ch_out = per_out[int'(sel)*NUM_PINS + p];
            ch_oe  = per_oe[int'(sel)*NUM_PINS + p];
        end

        // Choose between peripheral and GPIO ownership.
        always_comb begin
            if (func_en[p]) begin
                pin_out[p]                   = ch_out;
                pin_oe[p]                    = ch_oe;
                pin_fsel[p*SEL_W +: SEL_W]   = sel;
            end else begin
                pin_out[p]                   = data[p];
                pin_oe[p]                    = dir[p];
                pin_fsel[p*SEL_W +: SEL_W]   = '0;
            end
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
// Top of the multiplexed GPIO port: register file, input synchronizer,
// per-pin output steering and gated inputs for the interrupt block.
// Assumes a single-cycle write strobe and combinational reads.
module gpio_mux_port #(
    parameter int NUM_PINS = 16,
    parameter int NUM_FUNC = 4,
    parameter int DATA_W   = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   reg_wr,
    input  logic [2:0]                             reg_addr,
    input  logic [DATA_W-1:0]                      reg_wdata,
    output logic [DATA_W-1:0]                      reg_rdata,
    input  logic [NUM_PINS-1:0]                    pad_in,
    input  logic [NUM_FUNC*NUM_PINS-1:0]           per_out,
    input  logic [NUM_FUNC*NUM_PINS-1:0]           per_oe,
    output logic [NUM_PINS-1:0]                    pad_out,
    output logic [NUM_PINS-1:0]                    pad_oe,
    output logic [NUM_PINS*$clog2(NUM_FUNC)-1:0]   pad_fsel,
    output logic [NUM_PINS-1:0]                    pad_irq_src
);
    localparam int SEL_W = $clog2(NUM_FUNC);
    localparam int FS_W  = NUM_PINS * SEL_W;

    logic [NUM_PINS-1:0] func_en_q;
    logic [FS_W-1:0]     fsel_q;
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] in_en_q;
    logic [NUM_PINS-1:0] pin_sync;

    gpio_mux_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (pad_in),
        .d_sync (pin_sync)
    );

    gpio_mux_regs #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .pin_sync  (pin_sync),
        .rdata     (reg_rdata),
        .func_en_q (func_en_q),
        .fsel_q    (fsel_q),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .in_en_q   (in_en_q)
    );

    gpio_mux_pinsel #(.NUM_PINS(NUM_PINS), .NUM_FUNC(NUM_FUNC), .SEL_W(SEL_W)) u_pinsel (
        .func_en  (func_en_q),
        .fsel     (fsel_q),
        .data     (data_q),
        .dir      (dir_q),
        .per_out  (per_out),
        .per_oe   (per_oe),
        .pin_out  (pad_out),
        .pin_oe   (pad_oe),
        .pin_fsel (pad_fsel)
    );

    // Only input-enabled pins reach the interrupt block.
    assign pad_irq_src = pin_sync & in_en_q;

    AST_GPIO_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~func_en_q) == (dir_q & ~func_en_q))); // R3
    AST_GPIO_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pad_fsel) <= 2 * $countones(func_en_q))); // R11
endmodule

// File: tb/gpio_mux_port_bench.sv
`timescale 1ns/1ps
module gpio_mux_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] pad_in = '0;
    logic [63:0] per_out = '0;
    logic [63:0] per_oe = '0;
    logic [15:0] pad_out, pad_oe, pad_irq_src;
    logic [31:0] pad_fsel;

    int checks = 0;
    int failures = 0;
    bit started = 1'b0;

    always #2 clk = ~clk;

    gpio_mux_port u_gpio_mux_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .per_out(per_out), .per_oe(per_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_fsel(pad_fsel), .pad_irq_src(pad_irq_src)
    );

    // Behavioural reference state.
    logic [15:0] m_fen, m_lat, m_dir, m_inen;
    logic [31:0] m_fsel;
    logic [15:0] pad_hist[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Update the model on each edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_fen = '0; m_lat = '0; m_dir = '0; m_inen = '0; m_fsel = '0;
            pad_hist = '{16'h0, 16'h0};
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_fen = reg_wdata[15:0];
                    3'd1: m_fsel = reg_wdata;
                    3'd2: m_lat = reg_wdata[15:0];
                    3'd3: m_lat = m_lat | reg_wdata[15:0];
                    3'd4: m_lat = m_lat & ~reg_wdata[15:0];
                    3'd5: m_dir = m_dir | reg_wdata[15:0];
                    3'd6: m_dir = m_dir & ~reg_wdata[15:0];
                    default: m_inen = reg_wdata[15:0];
                endcase
            end
            pad_hist.push_front(pad_in);
            void'(pad_hist.pop_back());
        end
        started = 1'b1;
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (started) begin
            logic [15:0] e_out, e_oe, sync_v, e_rd;
            logic [31:0] e_sel;
            string rtag;
            sync_v = pad_hist[1];
            for (int p = 0; p < 16; p++) begin
                int s;
                s = int'(m_fsel[2*p +: 2]);
                if (m_fen[p]) begin
                    e_out[p] = per_out[s*16 + p];
                    e_oe[p]  = per_oe[s*16 + p];
                    e_sel[2*p +: 2] = m_fsel[2*p +: 2];
                end else begin
                    e_out[p] = m_lat[p];
                    e_oe[p]  = m_dir[p];
                    e_sel[2*p +: 2] = 2'b00;
                end
            end
            chk((m_fen == 16'h0) ? "R3 pad_out" : "R2 pad_out", {16'h0, pad_out}, {16'h0, e_out});
            chk((m_fen == 16'h0) ? "R3 pad_oe" : "R2 pad_oe", {16'h0, pad_oe}, {16'h0, e_oe});
            chk("R11 pad_fsel", pad_fsel, e_sel);
            chk("R8 irq", {16'h0, pad_irq_src}, {16'h0, sync_v & m_inen});
            case (reg_addr)
                3'd0: begin e_rd = m_fen; rtag = "R9 fen read"; end
                3'd2: begin e_rd = (m_inen & sync_v) | (~m_inen & m_lat); rtag = "R7 data read"; end
                3'd3: begin e_rd = m_lat; rtag = "R4 set read"; end
                3'd4: begin e_rd = m_lat; rtag = "R5 clr read"; end
                3'd5, 3'd6: begin e_rd = m_dir; rtag = "R6 dir read"; end
                3'd7: begin e_rd = m_inen; rtag = "R9 inen read"; end
                default: begin e_rd = '0; rtag = "R10 fsel read"; end
            endcase
            if (reg_addr == 3'd1) chk(rtag, reg_rdata, m_fsel);
            else chk(rtag, reg_rdata, {16'h0, e_rd});
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input string tag, input logic [31:0] exp);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", {16'h0, pad_oe}, 32'h0);
        rd_chk(3'd1, "R1 fsel after reset", 32'h0);
        wr_reg(3'd3, 32'h0000_00F0);
        rd_chk(3'd3, "R4 set", 32'h0000_00F0);
        wr_reg(3'd5, 32'h0000_FFFF);
        wr_reg(3'd4, 32'h0000_0030);
        @(negedge clk);
        chk("R5 clear", {16'h0, pad_out}, 32'h0000_00C0);
        wr_reg(3'd6, 32'h0000_00FF);
        @(negedge clk);
        chk("R6 dir clear", {16'h0, pad_oe}, 32'h0000_FF00);
        wr_reg(3'd2, 32'h0000_1234);
        rd_chk(3'd2, "R9 data write, latch when input off", 32'h0000_1234);
        wr_reg(3'd7, 32'h0000_FFFF);
        pad_in = 16'hA5A5;
        @(posedge clk); @(posedge clk); #1;
        rd_chk(3'd2, "R7 synced pad", 32'h0000_A5A5);
        chk("R8 irq", {16'h0, pad_irq_src}, 32'h0000_A5A5);
        wr_reg(3'd1, 32'hE4E4_E4E4);
        rd_chk(3'd1, "R10 fsel readback", 32'hE4E4_E4E4);
        per_out = {16'h0008, 16'h0004, 16'h0002, 16'h0001};
        wr_reg(3'd0, 32'h0000_000F);
        @(negedge clk);
        chk("R2 channel routing", {16'h0, pad_out}, 32'h0000_123F);
        chk("R11 select out", pad_fsel, 32'h0000_00E4);
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            rst_n     = ($urandom % 60) != 0;
            reg_wr    = $urandom % 2;
            reg_addr  = 3'($urandom % 8);
            reg_wdata = $urandom;
            pad_in    = 16'($urandom);
            per_out   = {$urandom, $urandom};
            per_oe    = {$urandom, $urandom};
        end
        @(posedge clk); #1;
        reg_wr = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule